// File: doc/BRIEF.md
# Dual-Mixer Beat Phase Detector

This block measures the phase offset between two clocks that share a nominal frequency. A helper clock runs slightly below that frequency. Here the helper is f × 2^TAG_W / (2^TAG_W + 1), with TAG_W = 14 for a 62.5 MHz reference. Each input clock is sampled as plain data by flip-flops in the helper domain. The sampled signals are slow square beat waves. Each beat period is exactly 2^TAG_W helper cycles, so the relative positions of the two beat edges magnify the input phase by 2^TAG_W. With the default values, one count is about 0.977 ps out of a 16 ns period.

Each channel passes through a sampling flop, a synchronizer chain and a run-length filter. The filter removes chatter that sampling an edge near the metastability window can produce. A free-running TAG_W-bit counter wraps once per beat period. The filter stamps each accepted rising beat edge with the counter value from the cycle its stable high run began. A pairing stage subtracts the A stamp from the following B stamp modulo 2^TAG_W and presents the result as a signed tag with a one-cycle valid strobe.

Top module: `ddmtd_phase_det`

## Requirements
- R1: While reset is asserted and after it is released, `phase_valid_o` is 0 and `phase_o` is 0 until the first pair of edges has been measured.
- R2: No tag is produced until an accepted edge has been seen on both channels. A B edge with no pending A edge is discarded, so a lone channel never produces a strobe.
- R3: Each tag equals (stamp_B − stamp_A) mod 2^TAG_W, read as a two's complement number in [−2^(TAG_W−1), 2^(TAG_W−1)−1]. Both stamps carry the same pipeline delay, so a beat on B that starts d helper cycles after the beat on A yields d wrapped to that signed range.
- R4: A rising beat edge is accepted only after the synchronized beat has stayed high for RUN_LEN consecutive helper cycles. Shorter high pulses produce no edge and leave later tags unchanged.
- R5: After an accepted rise, the beat must stay low for RUN_LEN consecutive cycles before another rise can be accepted. Low dips shorter than that inside a high phase produce no extra edge or tag.
- R6: Each accepted B edge that follows a pending A edge gives exactly one strobe and consumes that A edge. In steady state there is one tag per beat period.
- R7: A and B edges accepted in the same cycle are paired with each other and give a tag of 0.
- R8: The stamp counter is TAG_W bits wide, steps by one every helper cycle and wraps to 0. A beat whose period is 2^TAG_W cycles therefore gives the same tag every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_h | input | 1 | Offset helper clock; all logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| clk_a | input | 1 | First measured clock, sampled as data |
| clk_b | input | 1 | Second measured clock, sampled as data |
| phase_o | output | TAG_W | Signed phase tag, B relative to A, in stamp counts |
| phase_valid_o | output | 1 | One-cycle strobe marking a new tag |

## Verification
The assertions take for granted that each beat, once past the synchronizer, holds each level longer than RUN_LEN cycles apart from rare short chatter near its edges. They also assume that a channel's first post-reset high run is a genuine edge, not the tail of a half-seen pulse. The stimulus drives the beats as square waves locked to the helper clock, with a period equal to the counter span. Each channel is held low after reset until it reaches the middle of its low half, so every first accepted edge is genuine. Chatter is injected only as high pulses and low dips of RUN_LEN−1 cycles, placed well clear of the real transitions.

// File: rtl/ddmtd_pkg.sv
package ddmtd_pkg;
   typedef enum logic {
      LVL_LOW  = 1'b0,
      LVL_HIGH = 1'b1
   } lvl_state_e;
endpackage

// File: rtl/ddmtd_beat_sync.sv
module ddmtd_beat_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_h,
   input  logic rst,
   input  logic raw_i,
   output logic beat_o
);
   localparam int DEPTH = STAGES + 1;

   generate
      if (STAGES < 1) begin : g_bad
         $error("STAGES must be at least 1");
      end
   endgenerate

   logic [DEPTH-1:0] chain_q;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
         if (i == 0) begin : g_capture
            always_ff @(posedge clk_h) begin
               if (rst) chain_q[0] <= 1'b0;
               else     chain_q[0] <= raw_i;
            end
         end else begin : g_resync
            always_ff @(posedge clk_h) begin
               if (rst) chain_q[i] <= 1'b0;
               else     chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign beat_o = chain_q[DEPTH-1];
endmodule

// File: rtl/ddmtd_timebase.sv
module ddmtd_timebase #(
   parameter int TAG_W = 14
) (
   input  logic             clk_h,
   input  logic             rst,
   output logic [TAG_W-1:0] stamp_o
);
   generate
      if (TAG_W < 2) begin : g_bad
         $error("TAG_W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_h) begin
      if (rst) stamp_o <= '0;
      else     stamp_o <= stamp_o + 1'b1;
   end

   // R8: counter steps by one each cycle and wraps
   p_stamp_step_r8: assert property (@(posedge clk_h) disable iff (rst)
      (stamp_o != '0) |-> (stamp_o == $past(stamp_o) + 1'b1));
   p_stamp_wrap_r8: assert property (@(posedge clk_h) disable iff (rst)
      ($past(stamp_o) == {TAG_W{1'b1}}) |-> (stamp_o == '0));
endmodule

// File: rtl/ddmtd_deglitch.sv
module ddmtd_deglitch
   import ddmtd_pkg::*;
#(
   parameter int TAG_W   = 14,
   parameter int RUN_LEN = 8
) (
   input  logic             clk_h,
   input  logic             rst,
   input  logic             beat_i,
   input  logic [TAG_W-1:0] stamp_i,
   output logic             edge_o,
   output logic [TAG_W-1:0] tag_o
);
   localparam int CNT_W = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
   localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN_LEN - 1);

   generate
      if (RUN_LEN < 1) begin : g_bad
         $error("RUN_LEN must be at least 1");
      end
   endgenerate

   lvl_state_e       state_q;
   logic [CNT_W-1:0] run_q;
   logic [TAG_W-1:0] start_q;

   always_ff @(posedge clk_h) begin
      if (rst) begin
         state_q <= LVL_LOW;
         run_q   <= '0;
         start_q <= '0;
         edge_o  <= 1'b0;
         tag_o   <= '0;
      end else begin
         edge_o <= 1'b0;
         case (state_q)
            LVL_LOW: begin
               if (beat_i) begin
                  if (run_q == '0) start_q <= stamp_i;
                  if (run_q == RUN_LAST) begin
                     edge_o  <= 1'b1;
                     tag_o   <= (run_q == '0) ? stamp_i : start_q;
                     state_q <= LVL_HIGH;
                     run_q   <= '0;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end else begin
                  run_q <= '0;
               end
            end
            default: begin
               if (!beat_i) begin
                  if (run_q == RUN_LAST) begin
                     state_q <= LVL_LOW;
                     run_q   <= '0;
                  end else begin
                     run_q <= run_q + 1'b1;
                  end
               end else begin
                  run_q <= '0;
               end
            end
         endcase
      end
   end

   // R4: an accepted rise needs the beat high in the previous cycle
   p_rise_needs_high_r4: assert property (@(posedge clk_h) disable iff (rst)
      edge_o |-> $past(beat_i));
   // R5: two accepted rises are never adjacent
   p_no_double_rise_r5: assert property (@(posedge clk_h) disable iff (rst)
      edge_o |=> !edge_o);
endmodule

// File: rtl/ddmtd_pair.sv
module ddmtd_pair #(
   parameter int TAG_W = 14
) (
   input  logic                    clk_h,
   input  logic                    rst,
   input  logic                    edge_a_i,
   input  logic [TAG_W-1:0]        tag_a_i,
   input  logic                    edge_b_i,
   input  logic [TAG_W-1:0]        tag_b_i,
   output logic signed [TAG_W-1:0] phase_o,
   output logic                    valid_o
);
   logic             armed_q;
   logic [TAG_W-1:0] held_a_q;
   logic [TAG_W-1:0] ref_tag;
   logic             pair_now;

   assign ref_tag  = edge_a_i ? tag_a_i : held_a_q;
   assign pair_now = edge_b_i && (armed_q || edge_a_i);

   always_ff @(posedge clk_h) begin
      if (rst) begin
         armed_q  <= 1'b0;
         held_a_q <= '0;
         phase_o  <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (edge_a_i) begin
            held_a_q <= tag_a_i;
            armed_q  <= 1'b1;
         end
         if (pair_now) begin
            phase_o <= $signed(tag_b_i - ref_tag);
            valid_o <= 1'b1;
            armed_q <= 1'b0;
         end
      end
   end

   // R6: every strobe follows an accepted B edge
   p_valid_from_b_r6: assert property (@(posedge clk_h) disable iff (rst)
      valid_o |-> $past(edge_b_i));
   // R2: a B edge without a pending A edge gives no strobe
   p_lone_b_dropped_r2: assert property (@(posedge clk_h) disable iff (rst)
      (edge_b_i && !armed_q && !edge_a_i) |=> !valid_o);
   // R7: simultaneous edges with equal stamps give zero
   p_same_cycle_zero_r7: assert property (@(posedge clk_h) disable iff (rst)
      (edge_a_i && edge_b_i && tag_a_i == tag_b_i) |=> (phase_o == '0));
endmodule

// File: rtl/ddmtd_phase_det.sv
module ddmtd_phase_det #(
   parameter int TAG_W       = 14,
   parameter int RUN_LEN     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                    clk_h,
   input  logic                    rst,
   input  logic                    clk_a,
   input  logic                    clk_b,
   output logic signed [TAG_W-1:0] phase_o,
   output logic                    phase_valid_o
);
   localparam int NCH = 2;

   generate
      if (RUN_LEN >= (1 << (TAG_W - 1))) begin : g_bad
         $error("RUN_LEN must be shorter than half a beat period");
      end
   endgenerate

   logic [TAG_W-1:0] stamp;
   logic [NCH-1:0]   raw;
   logic [NCH-1:0]   beat;
   logic [NCH-1:0]   edge_acc;
   logic [TAG_W-1:0] tag [NCH];

   assign raw = {clk_b, clk_a};

   ddmtd_timebase #(.TAG_W(TAG_W)) u_timebase (
      .clk_h   (clk_h),
      .rst     (rst),
      .stamp_o (stamp)
   );

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         ddmtd_beat_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_h  (clk_h),
            .rst    (rst),
            .raw_i  (raw[ch]),
            .beat_o (beat[ch])
         );
         ddmtd_deglitch #(.TAG_W(TAG_W), .RUN_LEN(RUN_LEN)) u_filt (
            .clk_h   (clk_h),
            .rst     (rst),
            .beat_i  (beat[ch]),
            .stamp_i (stamp),
            .edge_o  (edge_acc[ch]),
            .tag_o   (tag[ch])
         );
      end
   endgenerate

   ddmtd_pair #(.TAG_W(TAG_W)) u_pair (
      .clk_h    (clk_h),
      .rst      (rst),
      .edge_a_i (edge_acc[0]),
      .tag_a_i  (tag[0]),
      .edge_b_i (edge_acc[1]),
      .tag_b_i  (tag[1]),
      .phase_o  (phase_o),
      .valid_o  (phase_valid_o)
   );

   // R1: no strobe in the cycle right after reset
   p_quiet_after_reset_r1: assert property (@(posedge clk_h)
      $past(rst) |-> !phase_valid_o);
endmodule

// File: tb/ddmtd_phase_det_bench.sv
`timescale 1ns/1ps
module ddmtd_phase_det_bench;
   localparam int TW   = 6;
   localparam int RL   = 3;
   localparam int SPAN = 1 << TW;
   localparam int HALF = SPAN / 2;

   logic clk_h = 1'b0;
   logic rst   = 1'b1;
   logic clk_a = 1'b0;
   logic clk_b = 1'b0;
   logic signed [TW-1:0] phase_o;
   logic phase_valid_o;

   int n_chk  = 0;
   int n_fail = 0;
   int t      = 0;
   bit done   = 1'b0;

   always #4 clk_h = ~clk_h;

   ddmtd_phase_det #(.TAG_W(TW), .RUN_LEN(RL), .SYNC_STAGES(2)) u_ddmtd_phase_det (
      .clk_h         (clk_h),
      .rst           (rst),
      .clk_a         (clk_a),
      .clk_b         (clk_b),
      .phase_o       (phase_o),
      .phase_valid_o (phase_valid_o)
   );

   function automatic bit lvl(int tt, int off, bit gl);
      int p;
      bit hi;
      p  = (tt - off) & (SPAN - 1);
      hi = (p < HALF);
      if (gl) begin
         if (p == SPAN - 4 || p == SPAN - 3) hi = 1'b1; // short high pulse, R4
         if (p == 10 || p == 11)             hi = 1'b0; // short low dip, R5
      end
      return hi;
   endfunction

   function automatic int exp_phase(int oa, int ob);
      int d;
      d = (ob - oa) & (SPAN - 1);
      if (d >= HALF) d = d - SPAN;
      return d;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   task automatic run_case(int oa, int ob, bit gl, bit en_a, bit en_b,
                           int vmin, int vmax, string req);
      bit ga, gb;
      int nv;
      bit bad;
      int bad_val;
      ga = 1'b0; gb = 1'b0; nv = 0; bad = 1'b0; bad_val = 0;
      rst = 1'b1;
      clk_a = 1'b0; clk_b = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk_h); t++;
      end
      check(phase_valid_o == 1'b0 && phase_o == '0, "R1", int'(phase_valid_o), 0);
      rst = 1'b0;
      for (int i = 0; i < 5 * SPAN; i++) begin
         @(negedge clk_h); t++;
         if (phase_valid_o) begin
            nv++;
            if (int'(phase_o) != exp_phase(oa, ob)) begin
               bad = 1'b1; bad_val = int'(phase_o);
            end
         end
         if (((t - oa) & (SPAN - 1)) == 40) ga = 1'b1;
         if (((t - ob) & (SPAN - 1)) == 40) gb = 1'b1;
         clk_a = en_a && ga && lvl(t, oa, gl);
         clk_b = en_b && gb && lvl(t, ob, gl);
      end
      if (vmax > 0)
         check(!bad, req, bad_val, exp_phase(oa, ob));
      check(nv >= vmin && nv <= vmax, (vmax > 0) ? "R6" : "R2", nv, vmax);
   endtask

   initial begin
      #(150000 * 8);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      // R2: one channel alone never yields a tag
      run_case(0, 20, 1'b0, 1'b0, 1'b1, 0, 0, "R2");
      run_case(0, 20, 1'b0, 1'b1, 1'b0, 0, 0, "R2");
      // R7: equal offsets give zero
      run_case(13, 13, 1'b0, 1'b1, 1'b1, 3, 5, "R7");
      // R3 / R8: full sweep of B offset against several A offsets
      for (int oa = 0; oa < SPAN; oa += 23)
         for (int ob = 0; ob < SPAN; ob++)
            run_case(oa, ob, 1'b0, 1'b1, 1'b1, 3, 5, "R3");
      // R4 / R5: chatter on both beats leaves tags unchanged
      for (int ob = 0; ob < SPAN; ob += 5)
         run_case(7, ob, 1'b1, 1'b1, 1'b1, 3, 5, "R4_R5");
      // R8: wrap extremes
      run_case(0, HALF, 1'b0, 1'b1, 1'b1, 3, 5, "R8");
      run_case(HALF, HALF - 1, 1'b0, 1'b1, 1'b1, 3, 5, "R8");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule